// File: doc/BRIEF.md
# Per-Bit Addressed Control and Status Register

This block holds a word of control, status and error flags in which every bit is reached through its own write address. A bus master never reads, modifies and writes back the word; it writes one word-aligned location, and that location touches exactly one flag. Data bit 0 of the write selects the action: 1 asserts the flag and 0 deasserts it. Each flag also carries fixed attributes, set by parameter masks. These say whether a hardware event may set the flag, whether software may set it, whether software may clear it, and whether the system reset forces it on or off.

Hardware event sources present a vector of single-cycle pulses, one per flag. Reads ignore the address. A read strobe captures the whole logical word, and it appears on the read data port one cycle later. A separate output gives the physical level of every flag. Flags whose signal is active low appear inverted on that output.

Top module: `bitaddr_ctl_reg`

## Requirements
- R1: A write to byte offset 4*n acts on flag n alone. All other flags keep their values.
- R2: In a write, data bit 0 = 1 sets the target flag and data bit 0 = 0 clears it. Data bits 31..1 have no effect.
- R3: A write is ignored when the flag lacks the matching software permission. With the default masks, software may set flags 1, 2, 5..14, 16..22 and 31, and may clear flags 0..30. Flag 31 cannot be cleared by software.
- R4: A 1 on `hw_evt[n]` sets flag n on the next edge when flag n is hardware-settable. With the default masks these are flags 0..4, 15, 16 and 23..30. Pulses on any other flag have no effect.
- R5: A hardware set and a software clear of the same flag in the same cycle leave the flag set.
- R6: While `sys_rst` is high, flags 7..10 are forced to 1 and flags 15 and 31 are forced to 0, whatever the hardware pulses and writes do. All other flags follow their normal rules during that cycle.
- R7: A write whose offset has bits 1..0 not equal to 00 changes no flag.
- R8: When `rd_en` is high at an edge, `rd_data` shows the full word as it stood before that edge from the following cycle on. It holds that value until the next read, and the address plays no part.
- R9: `pin_lvl` equals `state` with flags 14, 17, 19 and 20 inverted (XOR mask 0x001A4000). It follows `state` without delay.
- R10: Asynchronous `rst_n` low puts `state` at 0x00000780 (flags 7..10 set) and `rd_data` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system reset, forces the reset-set and reset-clear flags |
| wr_en | input | 1 | Write strobe |
| bus_addr | input | 7 | Byte offset inside the register window |
| wr_data | input | 32 | Write data; only bit 0 is used |
| rd_en | input | 1 | Read strobe |
| hw_evt | input | 32 | Hardware set pulses, one per flag |
| rd_data | output | 32 | Captured logical word |
| state | output | 32 | Current logical flags |
| pin_lvl | output | 32 | Physical levels with active-low flags inverted |

## Verification
Writes, hardware pulses and system resets reach `state` one edge after they are applied, and `pin_lvl` follows in the same cycle. A read shows on `rd_data` one edge after its strobe and carries the value from before that edge. The bench drives each cycle's inputs after the falling edge and updates its behavioural model at the rising edge. It then compares all three outputs a quarter period later, so every compare lands after exactly one register stage. The only check made without a clock edge is the asynchronous reset, which is compared while `rst_n` is still low.

// File: rtl/bitcmd_pkg.sv
package bitcmd_pkg;

   // default attribute masks, one bit per flag
   localparam logic [31:0] DEF_HW_SET  = 32'h7F81_801F;
   localparam logic [31:0] DEF_SW_SET  = 32'h807F_7FE6;
   localparam logic [31:0] DEF_SW_CLR  = 32'h7FFF_FFFF;
   localparam logic [31:0] DEF_RST_SET = 32'h0000_0780;
   localparam logic [31:0] DEF_RST_CLR = 32'h8000_8000;
   localparam logic [31:0] DEF_ACT_LOW = 32'h001A_4000;

   typedef struct packed {
      logic hw_set;
      logic sw_set;
      logic sw_clr;
      logic rst_set;
      logic rst_clr;
   } bit_attr_t;

   function automatic bit_attr_t pick_attr(
      input logic [31:0] hw_m,
      input logic [31:0] sws_m,
      input logic [31:0] swc_m,
      input logic [31:0] rs_m,
      input logic [31:0] rc_m,
      input int          idx
   );
      bit_attr_t a;
      a.hw_set  = hw_m[idx];
      a.sw_set  = sws_m[idx];
      a.sw_clr  = swc_m[idx];
      a.rst_set = rs_m[idx];
      a.rst_clr = rc_m[idx];
      return a;
   endfunction

endpackage

// File: rtl/bitcmd_decode.sv
module bitcmd_decode #(
   parameter int NBITS  = 32,
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [NBITS-1:0]  set_strb,
   output logic [NBITS-1:0]  clr_strb
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             aligned;
   logic             hit;
   logic             unused_hi;

   assign idx       = addr[ADDR_W-1:2];
   assign aligned   = (addr[1:0] == 2'b00);
   assign hit       = wr_en & aligned;
   assign unused_hi = ^wr_data[DATA_W-1:1];

   for (genvar g = 0; g < NBITS; g++) begin : g_sel
      logic sel;
      assign sel         = hit && (idx == IDX_W'(g));
      assign set_strb[g] = sel & wr_data[0];
      assign clr_strb[g] = sel & ~wr_data[0];
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_strb | clr_strb)); // R1
   AST_MISALIGNED_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[1:0] != 2'b00) |-> ((set_strb | clr_strb) == '0)); // R7

endmodule

// File: rtl/bitcmd_cell.sv
module bitcmd_cell
   import bitcmd_pkg::*;
#(
   parameter bit_attr_t ATTR = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_rst_i,
   input  logic hw_set_i,
   input  logic sw_set_i,
   input  logic sw_clr_i,
   output logic q_o
);
   logic hw_go, sws_go, swc_go, rs_go, rc_go;
   logic q_d;

   assign hw_go  = hw_set_i  & ATTR.hw_set;
   assign sws_go = sw_set_i  & ATTR.sw_set;
   assign swc_go = sw_clr_i  & ATTR.sw_clr;
   assign rs_go  = sys_rst_i & ATTR.rst_set;
   assign rc_go  = sys_rst_i & ATTR.rst_clr;

   // priority: system reset, then hardware event, then software write
   always_comb begin
      q_d = q_o;
      if (rs_go)       q_d = 1'b1;
      else if (rc_go)  q_d = 1'b0;
      else if (hw_go)  q_d = 1'b1;
      else if (sws_go) q_d = 1'b1;
      else if (swc_go) q_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= ATTR.rst_set;
      else        q_o <= q_d;
   end

   if (ATTR.hw_set) begin : g_hw_chk
      AST_HW_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         (hw_set_i && !sys_rst_i) |=> q_o); // R5
   end
   if (ATTR.rst_set) begin : g_rs_chk
      AST_SYSRST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         sys_rst_i |=> q_o); // R6
   end
   if (ATTR.rst_clr) begin : g_rc_chk
      AST_SYSRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         sys_rst_i |=> !q_o); // R6
   end
   if (ATTR.sw_clr && !ATTR.rst_set) begin : g_clr_chk
      AST_SW_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_clr_i && !hw_set_i && !sys_rst_i) |=> !q_o); // R2
   end
   if (!ATTR.sw_set && !ATTR.hw_set && !ATTR.rst_set) begin : g_nos_chk
      AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_set_i && !q_o) |=> !q_o); // R3
   end

endmodule

// File: rtl/bitcmd_readout.sv
module bitcmd_readout #(
   parameter int          NBITS   = 32,
   parameter int          DATA_W  = 32,
   parameter logic [31:0] ACT_LOW = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [NBITS-1:0]  state_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [NBITS-1:0]  pin_o
);
   logic [DATA_W-1:0] word;

   if (DATA_W == NBITS) begin : g_full
      assign word = state_i;
   end else begin : g_pad
      assign word = {{(DATA_W-NBITS){1'b0}}, state_i};
   end

   assign pin_o = state_i ^ ACT_LOW[NBITS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data_o <= '0;
      else if (rd_en) rd_data_o <= word;
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data_o)); // R8
   AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rd_data_o == $past(word))); // R8

endmodule

// File: rtl/bitaddr_ctl_reg.sv
module bitaddr_ctl_reg
   import bitcmd_pkg::*;
#(
   parameter int          NBITS    = 32,
   parameter int          DATA_W   = 32,
   parameter logic [31:0] HW_SET_MASK  = DEF_HW_SET,
   parameter logic [31:0] SW_SET_MASK  = DEF_SW_SET,
   parameter logic [31:0] SW_CLR_MASK  = DEF_SW_CLR,
   parameter logic [31:0] RST_SET_MASK = DEF_RST_SET,
   parameter logic [31:0] RST_CLR_MASK = DEF_RST_CLR,
   parameter logic [31:0] ACT_LOW_MASK = DEF_ACT_LOW,
   localparam int         ADDR_W   = $clog2(4 * NBITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [NBITS-1:0]  hw_evt,
   output logic [DATA_W-1:0] rd_data,
   output logic [NBITS-1:0]  state,
   output logic [NBITS-1:0]  pin_lvl
);
   // elaboration-time parameter checks
   if (NBITS < 2 || NBITS > 32) begin : g_bad_nbits
      $error("NBITS must lie in 2..32");
   end
   if (DATA_W < NBITS) begin : g_bad_dw
      $error("DATA_W must be at least NBITS");
   end
   if ((RST_SET_MASK & RST_CLR_MASK) != 32'h0) begin : g_bad_rst
      $error("a flag cannot be both reset-set and reset-clear");
   end

   logic [NBITS-1:0] set_strb;
   logic [NBITS-1:0] clr_strb;

   bitcmd_decode #(
      .NBITS  (NBITS),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (bus_addr),
      .wr_data  (wr_data),
      .set_strb (set_strb),
      .clr_strb (clr_strb)
   );

   for (genvar g = 0; g < NBITS; g++) begin : g_flag
      localparam bit_attr_t A = pick_attr(HW_SET_MASK, SW_SET_MASK,
                                          SW_CLR_MASK, RST_SET_MASK,
                                          RST_CLR_MASK, g);
      bitcmd_cell #(.ATTR(A)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .sys_rst_i (sys_rst),
         .hw_set_i  (hw_evt[g]),
         .sw_set_i  (set_strb[g]),
         .sw_clr_i  (clr_strb[g]),
         .q_o       (state[g])
      );
   end

   bitcmd_readout #(
      .NBITS   (NBITS),
      .DATA_W  (DATA_W),
      .ACT_LOW (ACT_LOW_MASK)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .state_i   (state),
      .rd_data_o (rd_data),
      .pin_o     (pin_lvl)
   );

   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !sys_rst && hw_evt == '0) |=> $stable(state)); // R1

endmodule

// File: tb/bitaddr_ctl_reg_tb.sv
module bitaddr_ctl_reg_tb_top;
   localparam int CLK_P = 10;

   // expected attributes, taken from the requirements
   localparam logic [31:0] M_HW  = 32'h7F81_801F; // R4
   localparam logic [31:0] M_SWS = 32'h807F_7FE6; // R3
   localparam logic [31:0] M_SWC = 32'h7FFF_FFFF; // R3
   localparam logic [31:0] M_RS  = 32'h0000_0780; // R6
   localparam logic [31:0] M_RC  = 32'h8000_8000; // R6
   localparam logic [31:0] M_AL  = 32'h001A_4000; // R9

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sys_rst = 1'b0;
   logic        wr_en = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] hw_evt = '0;
   logic [31:0] rd_data, state, pin_lvl;

   int n_vec = 0;
   int n_bad = 0;
   logic [31:0] m_state;
   logic [31:0] m_rd;

   always #(CLK_P/2) clk = ~clk;

   bitaddr_ctl_reg dut_i (
      .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .wr_en(wr_en),
      .bus_addr(bus_addr), .wr_data(wr_data), .rd_en(rd_en),
      .hw_evt(hw_evt), .rd_data(rd_data), .state(state), .pin_lvl(pin_lvl)
   );

   task automatic cmp(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      cmp(tag, "state", state, m_state);
      cmp({tag, "/R9"}, "pin_lvl", pin_lvl, m_state ^ M_AL);
      cmp({tag, "/R8"}, "rd_data", rd_data, m_rd);
   endtask

   // one clock: drive after the falling edge, model at the rising edge, compare after it
   task automatic cyc(input string tag, input logic we, input logic [6:0] a,
                      input logic [31:0] d, input logic [31:0] hw,
                      input logic sr, input logic re);
      logic [31:0] nxt;
      wr_en = we; bus_addr = a; wr_data = d; hw_evt = hw; sys_rst = sr; rd_en = re;
      @(posedge clk);
      if (re) m_rd = m_state;
      nxt = m_state;
      for (int i = 0; i < 32; i++) begin
         if (sr && M_RS[i])      nxt[i] = 1'b1;
         else if (sr && M_RC[i]) nxt[i] = 1'b0;
         else if (hw[i] && M_HW[i]) nxt[i] = 1'b1;
         else if (we && a[1:0] == 2'b00 && int'(a[6:2]) == i) begin
            if (d[0] && M_SWS[i])       nxt[i] = 1'b1;
            else if (!d[0] && M_SWC[i]) nxt[i] = 1'b0;
         end
      end
      m_state = nxt;
      #(CLK_P/4);
      check_all(tag);
      @(negedge clk);
      wr_en = 1'b0; sys_rst = 1'b0; rd_en = 1'b0; hw_evt = '0;
   endtask

   task automatic por();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      m_state = M_RS; m_rd = '0;
      check_all("R10");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      m_state = M_RS; m_rd = '0;
      repeat (2) @(negedge clk);
      check_all("R10");                     // reset value 0x00000780
      rst_n = 1'b1;
      cyc("R1", 0, 0, 0, 0, 0, 0);          // idle holds

      // R4: every hardware pulse, only permitted flags set
      cyc("R4", 0, 0, 0, 32'hFFFF_FFFF, 0, 0);
      cyc("R8", 0, 7'h44, 0, 0, 0, 1);      // read, address ignored
      cyc("R8", 0, 0, 0, 0, 0, 0);          // read data holds

      // R1/R2/R3: software set of each flag, upper data bits all ones
      for (int i = 0; i < 32; i++)
         cyc("R3", 1, 7'(i * 4), 32'hFFFF_FFFF, 0, 0, 0);
      cyc("R8", 0, 0, 0, 0, 0, 1);
      // R2/R3: software clear of each flag, upper data bits ones, bit 0 zero
      for (int i = 0; i < 32; i++)
         cyc("R2", 1, 7'(i * 4), 32'hFFFF_FFFE, 0, 0, 0);
      cyc("R8", 0, 0, 0, 0, 0, 1);

      // R7: misaligned writes do nothing
      cyc("R7", 1, 7'h09, 32'h1, 0, 0, 0);
      cyc("R7", 1, 7'h16, 32'h1, 0, 0, 0);
      cyc("R7", 1, 7'h7F, 32'h1, 0, 0, 0);
      cyc("R1", 1, 7'h08, 32'h1, 0, 0, 0);  // flag 2 alone
      cyc("R1", 1, 7'h14, 32'h1, 0, 0, 0);  // flag 5 alone

      // R5: hardware set beats software clear in the same cycle
      cyc("R5", 0, 0, 0, 32'h0000_0001, 0, 0);
      cyc("R5", 1, 7'h00, 32'h0, 32'h0000_0001, 0, 0);
      cyc("R5", 1, 7'h00, 32'h0, 0, 0, 0);
      cyc("R5", 1, 7'h5C, 32'h0, 32'h0080_0000, 0, 0);

      // R6: system reset against hardware pulses and a write
      cyc("R6", 1, 7'h7C, 32'h1, 0, 0, 0);   // set flag 31
      cyc("R6", 1, 7'h1C, 32'h0, 0, 0, 0);   // clear flag 7
      cyc("R6", 1, 7'h20, 32'h0, 0, 0, 0);   // clear flag 8
      cyc("R6", 0, 0, 0, 32'h0000_8000, 0, 0); // hw sets flag 15
      cyc("R6", 1, 7'h1C, 32'h0, 32'hFFFF_FFFF, 1, 0);
      cyc("R6", 1, 7'h7C, 32'h1, 0, 1, 1);
      cyc("R8", 0, 0, 0, 0, 0, 0);

      // R3: flag 31 cannot be cleared by software
      cyc("R3", 1, 7'h7C, 32'h1, 0, 0, 0);
      cyc("R3", 1, 7'h7C, 32'h0, 0, 0, 0);
      cyc("R4", 0, 0, 0, 32'h0000_7FE0, 0, 0); // non-hw flags ignore pulses

      por();                                   // R10 mid-run
      cyc("R10", 0, 0, 0, 0, 0, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule